// File: doc/BRIEF.md
# System Control Register Bank

This block is a memory-mapped bank of 32-bit words that sits on a simple peripheral bus. The bus has a byte address, separate read and write strobes, write data and registered read data. Software uses the bank for scratch storage and for a few status words that come out of reset with fixed values.

The bus window is 4 KiB wide, but only the lower part is backed by storage. Word index is the byte address divided by four. One byte offset inside the unbacked upper part acts as a control port. Writing a command value there sends a single-cycle warm-reset request or power-off request to the rest of the system. Three status offsets always read back with two fixed bits set, while the stored word stays unchanged.

An access that falls outside the backed storage has no effect on any word. Such a read returns zero, and the access raises a one-cycle error pulse for the system's error logging.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121, word 0x43 holds 0x05F40121, every other word holds zero, and all three pulse outputs are low.
- R2: A write with word index (address bits [11:2]) below 512 stores the write data in that word. A read strobe returns the word on `bus_rdata` one cycle after the strobe. `bus_rdata` holds its value while no read is made.
- R3: A write with word index 512 or more changes no stored word. In particular, it does not alias onto the word whose index matches the lower nine bits.
- R4: A read with word index 512 or more returns zero.
- R5: A write of data 1 or 2 to byte offset 0xF00 makes `warm_reset_req` high for exactly the cycle after the write.
- R6: A write of data 3 to byte offset 0xF00 makes `power_off_req` high for exactly the cycle after the write.
- R7: Any other write data at 0xF00, any read of 0xF00, and any access at another offset leaves both request outputs low. The two requests are never high together.
- R8: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000, and the stored word itself is not changed. No other offset gets this overlay.
- R9: `access_error` is high for one cycle after any read or write whose word index is 512 or more, including the control offset. It stays low after in-range accesses.
- R10: When a read and a write hit the same word in one cycle, the read returns the value stored before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address within the window, word aligned |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after `bus_rd` |
| warm_reset_req | output | 1 | One-cycle warm-reset request |
| power_off_req | output | 1 | One-cycle power-off request |
| access_error | output | 1 | One-cycle pulse after an out-of-range access |

## Verification
Two functions can meet in the same cycle:
- A read and a write that both strobe one word. The bench drives both strobes in one cycle and expects the old word on the read data. A later read then has to show the new word.
- The status-bit overlay and an ordinary write. Software writing zero to an overlaid offset must still read back the two forced bits, and a plain neighbouring offset must not get them.

Random traffic mixes all three access kinds over the whole window, with command values aimed at the control offset. Every response is compared against a model kept by the bench.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   // word indexes whose read data carries the forced status bits
   localparam int unsigned SC_OVL_COUNT = 3;
   localparam int unsigned SC_OVL_IDX [SC_OVL_COUNT] = '{32'h40, 32'h42, 32'h43};

   // command values recognised at the control offset
   typedef enum logic [1:0] {
      SC_CMD_NONE = 2'd0,
      SC_CMD_WARM = 2'd1,
      SC_CMD_OFF  = 2'd2
   } sc_cmd_e;

   function automatic logic [31:0] sc_reset_word(input int unsigned idx);
      logic [31:0] v;
      case (idx)
         32'h40:  v = 32'h05F2_0121;
         32'h41:  v = 32'h0000_0002;
         32'h42:  v = 32'h05F3_0121;
         32'h43:  v = 32'h05F4_0121;
         default: v = 32'h0;
      endcase
      return v;
   endfunction

   function automatic sc_cmd_e sc_decode_cmd(input logic [31:0] data);
      sc_cmd_e c;
      case (data)
         32'd1, 32'd2: c = SC_CMD_WARM;
         32'd3:        c = SC_CMD_OFF;
         default:      c = SC_CMD_NONE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_WORDS = 512,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word
);
   import sysctl_pkg::*;

   logic [DATA_W-1:0] mem [NUM_WORDS];

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(sc_reset_word(i));
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem[i] <= RST_VAL;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            mem[i] <= wr_data;
      end
   end

   assign rd_word = mem[rd_idx];

endmodule

// File: rtl/sysctl_ctrl_decode.sv
module sysctl_ctrl_decode #(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'hF00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              warm_req,
   output logic              off_req
);
   import sysctl_pkg::*;

   sc_cmd_e cmd;

   always_comb begin
      cmd = SC_CMD_NONE;
      if (wr && (addr == CTRL_OFFSET))
         cmd = sc_decode_cmd(32'(wdata));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         warm_req <= 1'b0;
         off_req  <= 1'b0;
      end else begin
         warm_req <= (cmd == SC_CMD_WARM);
         off_req  <= (cmd == SC_CMD_OFF);
      end
   end

endmodule

// File: rtl/sysctl_rd_path.sv
module sysctl_rd_path #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned WIDX_W  = 10,
   parameter logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              in_range,
   input  logic [WIDX_W-1:0] widx,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rdata
);
   import sysctl_pkg::*;

   logic [SC_OVL_COUNT-1:0] ovl_match;

   for (genvar k = 0; k < SC_OVL_COUNT; k++) begin : g_ovl
      assign ovl_match[k] = (widx == WIDX_W'(SC_OVL_IDX[k]));
   end

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      if (!in_range)
         rd_next = '0;
      else if (|ovl_match)
         rd_next = word | FORCE_MASK;
      else
         rd_next = word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd)
         rdata <= rd_next;
   end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_WORDS = 512,
   parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'hF00,
   parameter logic [DATA_W-1:0] FORCE_MASK  = 32'h3000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              warm_reset_req,
   output logic              power_off_req,
   output logic              access_error
);
   localparam int unsigned WIDX_W = ADDR_W - 2;
   localparam int unsigned IDX_W  = $clog2(NUM_WORDS);

   if (DATA_W != 32) begin : g_bad_width
      $error("sysctl_regbank: only 32-bit words are supported");
   end
   if (NUM_WORDS < 2 || NUM_WORDS > (1 << WIDX_W)) begin : g_bad_depth
      $error("sysctl_regbank: NUM_WORDS must fit in the address window");
   end

   logic [WIDX_W-1:0] widx;
   logic              in_range;
   logic [DATA_W-1:0] word;

   assign widx     = bus_addr[ADDR_W-1:2];
   assign in_range = {1'b0, widx} < (WIDX_W+1)'(NUM_WORDS);

   sysctl_store #(
      .DATA_W    (DATA_W),
      .NUM_WORDS (NUM_WORDS)
   ) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr && in_range),
      .wr_idx  (widx[IDX_W-1:0]),
      .wr_data (bus_wdata),
      .rd_idx  (widx[IDX_W-1:0]),
      .rd_word (word)
   );

   sysctl_ctrl_decode #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .CTRL_OFFSET (CTRL_OFFSET)
   ) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .warm_req (warm_reset_req),
      .off_req  (power_off_req)
   );

   sysctl_rd_path #(
      .DATA_W     (DATA_W),
      .WIDX_W     (WIDX_W),
      .FORCE_MASK (FORCE_MASK)
   ) rd_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (bus_rd),
      .in_range (in_range),
      .widx     (widx),
      .word     (word),
      .rdata    (bus_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         access_error <= 1'b0;
      else
         access_error <= (bus_wr || bus_rd) && !in_range;
   end

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_WORDS = 512,
   parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'hF00,
   parameter logic [DATA_W-1:0] FORCE_MASK  = 32'h3000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              warm_reset_req,
   input logic              power_off_req,
   input logic              access_error
);
   logic oob, ctl_wr, ovl_rd;
   assign oob    = {1'b0, bus_addr[ADDR_W-1:2]} >= (ADDR_W-1)'(NUM_WORDS);
   assign ctl_wr = bus_wr && (bus_addr == CTRL_OFFSET);
   assign ovl_rd = bus_rd && ((bus_addr == ADDR_W'('h100)) ||
                              (bus_addr == ADDR_W'('h108)) ||
                              (bus_addr == ADDR_W'('h10C)));

   a_r5_warm_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && (bus_wdata == 1 || bus_wdata == 2)) |=> warm_reset_req);
   a_r5_warm_cause: assert property (@(posedge clk) disable iff (!rst_n)
      warm_reset_req |-> $past(ctl_wr && (bus_wdata == 1 || bus_wdata == 2)));
   a_r6_off_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata == 3) |=> power_off_req);
   a_r6_off_cause: assert property (@(posedge clk) disable iff (!rst_n)
      power_off_req |-> $past(ctl_wr && bus_wdata == 3));
   a_r7_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(warm_reset_req && power_off_req));
   a_r4_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && oob) |=> (bus_rdata == '0));
   a_r8_forced_bits: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_rd |=> ((bus_rdata & FORCE_MASK) == FORCE_MASK));
   a_r9_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && oob) |=> access_error);
   a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      access_error |-> $past((bus_wr || bus_rd) && oob));
   a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

endmodule

bind sysctl_regbank sysctl_regbank_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .NUM_WORDS   (NUM_WORDS),
   .CTRL_OFFSET (CTRL_OFFSET),
   .FORCE_MASK  (FORCE_MASK)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_addr       (bus_addr),
   .bus_wr         (bus_wr),
   .bus_rd         (bus_rd),
   .bus_wdata      (bus_wdata),
   .bus_rdata      (bus_rdata),
   .warm_reset_req (warm_reset_req),
   .power_off_req  (power_off_req),
   .access_error   (access_error)
);

// File: tb/sysctl_regbank_tb_top.sv
module sysctl_regbank_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        warm_reset_req, power_off_req, access_error;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] model [512];

   always #4 clk = ~clk;   // 125 MHz

   sysctl_regbank dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_addr       (bus_addr),
      .bus_wr         (bus_wr),
      .bus_rd         (bus_rd),
      .bus_wdata      (bus_wdata),
      .bus_rdata      (bus_rdata),
      .warm_reset_req (warm_reset_req),
      .power_off_req  (power_off_req),
      .access_error   (access_error)
   );

   function automatic void model_reset();
      for (int i = 0; i < 512; i++) model[i] = 32'h0;
      model['h40] = 32'h05F2_0121;   // R1
      model['h41] = 32'h0000_0002;
      model['h42] = 32'h05F3_0121;
      model['h43] = 32'h05F4_0121;
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      logic [31:0] v;
      if (a[11:2] >= 10'd512) return 32'h0;              // R4
      v = model[a[10:2]];
      if (a == 12'h100 || a == 12'h108 || a == 12'h10C)
         v = v | 32'h3000_0000;                          // R8
      return v;
   endfunction

   function automatic bit exp_warm(input bit w, input logic [11:0] a, input logic [31:0] d);
      return w && a == 12'hF00 && (d == 32'd1 || d == 32'd2);
   endfunction

   function automatic bit exp_off(input bit w, input logic [11:0] a, input logic [31:0] d);
      return w && a == 12'hF00 && d == 32'd3;
   endfunction

   function automatic bit exp_err(input bit w, input bit r, input logic [11:0] a);
      return (w || r) && a[11:2] >= 10'd512;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // one bus cycle; called at a falling edge, returns at the next one
   task automatic op(input bit w, input bit r, input logic [11:0] a,
                     input logic [31:0] d, input string req);
      logic [31:0] er;
      er = exp_read(a);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      if (r) check(req, bus_rdata, er);
      check(w && a == 12'hF00 ? "R5 warm" : "R7 warm", 32'(warm_reset_req), 32'(exp_warm(w, a, d)));
      check(w && a == 12'hF00 ? "R6 off" : "R7 off", 32'(power_off_req), 32'(exp_off(w, a, d)));
      check("R9 error", 32'(access_error), 32'(exp_err(w, r, a)));
      if (w && a[11:2] < 10'd512) model[a[10:2]] = d;
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic idle_check();
      @(negedge clk);
      check("R5 pulse width", 32'(warm_reset_req), 32'h0);
      check("R6 pulse width", 32'(power_off_req), 32'h0);
      check("R9 pulse width", 32'(access_error), 32'h0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [11:0] a;
      logic [31:0] d;
      int unsigned sel;
      void'($urandom(32'h5C17_0A11));
      model_reset();
      repeat (3) @(negedge clk);
      check("R1 warm at reset", 32'(warm_reset_req), 32'h0);
      check("R1 off at reset", 32'(power_off_req), 32'h0);
      check("R1 error at reset", 32'(access_error), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R8: reset words, overlay on three of them
      op(0, 1, 12'h100, 0, "R1 R8 word 0x40");
      op(0, 1, 12'h104, 0, "R1 word 0x41");
      op(0, 1, 12'h108, 0, "R1 R8 word 0x42");
      op(0, 1, 12'h10C, 0, "R1 R8 word 0x43");
      op(0, 1, 12'h000, 0, "R1 word 0");
      op(0, 1, 12'h7FC, 0, "R1 last word");

      // R8: stored word unchanged by overlay; neighbour not forced
      op(1, 0, 12'h100, 32'h0, "R2");
      op(0, 1, 12'h100, 0, "R8 zero stored");
      op(1, 0, 12'h104, 32'hCFFF_0000, "R2");
      op(0, 1, 12'h104, 0, "R8 plain neighbour");

      // R2: edge words
      op(1, 0, 12'h7FC, 32'hA5A5_5A5A, "R2");
      op(0, 1, 12'h7FC, 0, "R2 last word");
      idle_check();

      // R3 / R4 / R9: out of range, no aliasing
      op(1, 0, 12'h800, 32'hDEAD_BEEF, "R3");
      op(0, 1, 12'h000, 0, "R3 no alias word 0");
      op(1, 0, 12'hBFC, 32'h1234_5678, "R3");
      op(0, 1, 12'h3FC, 0, "R3 no alias word 0xFF");
      op(0, 1, 12'h800, 0, "R4 oob read");
      op(0, 1, 12'hFFC, 0, "R4 top read");

      // R5 / R6 / R7: control offset
      op(1, 0, 12'hF00, 32'd1, "R5");
      idle_check();
      op(1, 0, 12'hF00, 32'd2, "R5");
      op(1, 0, 12'hF00, 32'd2, "R5 back to back");
      idle_check();
      op(1, 0, 12'hF00, 32'd3, "R6");
      idle_check();
      op(1, 0, 12'hF00, 32'd0, "R7");
      op(1, 0, 12'hF00, 32'd4, "R7");
      op(1, 0, 12'hF00, 32'h101, "R7");
      op(0, 1, 12'hF00, 0, "R7 R4 read ctl");
      op(1, 0, 12'hF04, 32'd1, "R7");
      op(1, 0, 12'h300, 32'd1, "R7");

      // R10: read and write together
      op(1, 1, 12'h200, 32'hCAFE_F00D, "R10 old value");
      op(0, 1, 12'h200, 0, "R10 new value");
      op(1, 1, 12'h108, 32'h0000_00FF, "R10 R8 old value");
      op(0, 1, 12'h108, 0, "R10 R8 new value");

      // random mix
      for (int n = 0; n < 2000; n++) begin
         sel = $urandom_range(0, 9);
         if (sel < 6)       a = {1'b0, 11'($urandom_range(0, 511) << 2)};
         else if (sel < 8)  a = 12'($urandom_range(512, 1023) << 2);
         else               a = 12'hF00;
         sel = $urandom_range(0, 7);
         d = (a == 12'hF00 && sel < 5) ? 32'(sel) : $urandom();
         sel = $urandom_range(0, 2);
         op(sel != 1, sel != 0, a, d, "R2 R10 random");
      end

      done = 1'b1;
      finish_run();
   end

endmodule